// File: doc/BRIEF.md
# Character-Driven JTAG Pin Sequencer

This block turns a stream of single-byte ASCII commands into levels on the four JTAG pins of a target: test clock, mode select, data in and the active-low test reset. A host-side agent feeds bytes over a valid/ready command channel. Each byte either sets the three signal pins at once, moves the test reset, asks for the current level of the target's data-out pin, or closes the session. The block never toggles the test clock on its own. The host builds every clock edge out of explicit pin commands.

A read command produces one ASCII reply byte on a separate valid/ready reply channel. While a reply waits for the consumer, the command channel stalls. Replies therefore leave in command order and none is lost. The data-out pin is asynchronous to the block clock, so it passes through a parameterised flop chain before it is sampled. A one-cycle step pulse marks every command that counts as a clock step. A sticky quit output reports the end of the session.

The control FSM has three states. `ST_IDLE` accepts commands. `ST_REPLY` holds a reply byte until the consumer takes it. `ST_QUIT` is terminal until reset. The transitions are:
- *read-accepted*: `ST_IDLE` to `ST_REPLY`.
- *reply-taken*: `ST_REPLY` to `ST_IDLE`.
- *quit-accepted*: `ST_IDLE` to `ST_QUIT`.
- *hold*: every other case, where the FSM keeps its current state.

Top module: `jtag_char_driver`

## Requirements
- R1: During and after reset, tck, tms, tdi, trst_n, step, rsp_valid and quit are all 0, and cmd_ready is 1.
- R2: Accepting a byte from 0x30 to 0x37 ('0' to '7') sets the pins one clock later from the low three bits of the byte: bit 2 drives tck, bit 1 drives tms and bit 0 drives tdi.
- R3: Accepting 'r' (0x72) or 's' (0x73) drives trst_n to 1 one clock later. Accepting 't' (0x74) or 'u' (0x75) drives trst_n to 0 one clock later. None of these four commands changes tck, tms or tdi.
- R4: step is high for exactly the one cycle after a digit command or a release command ('r' or 's') is accepted. It stays low after every other command.
- R5: Accepting 'R' (0x52) emits one reply byte. The byte is 0x31 when the synchronised tdo is high and 0x30 when it is low. tdo is synchronised through SYNC_STAGES flops. The pins do not change.
- R6: A pending reply keeps rsp_valid high and rsp_byte stable until rsp_ready is seen. cmd_ready is low for as long as the reply is pending.
- R7: Accepting 'Q' (0x51) sets quit, and quit stays set until reset. Every later byte is still accepted but changes no pin, produces no step and produces no reply.
- R8: A byte that matches no defined command is accepted and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command byte is offered |
| cmd_ready | output | 1 | The block accepts the offered byte |
| cmd_byte | input | 8 | ASCII command |
| rsp_valid | output | 1 | A reply byte is pending |
| rsp_ready | input | 1 | The consumer takes the reply |
| rsp_byte | output | 8 | ASCII '0' or '1' |
| tdo | input | 1 | Target data out, asynchronous |
| tck | output | 1 | Test clock pin |
| tms | output | 1 | Mode select pin |
| tdi | output | 1 | Data in pin |
| trst_n | output | 1 | Active-low test reset pin |
| step | output | 1 | One-cycle pulse per step command |
| quit | output | 1 | Sticky end-of-session flag |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default of 2. This exercises the multi-stage branch of the synchroniser generate, and it confirms that a tdo change reaches the reply only after the longer chain has settled. The bench holds the reply consumer off while a digit command is offered. This shows that the command stalls and that the reply byte stays frozen. The bench then sends bytes after the quit command to show that each one is absorbed without effect.

// File: rtl/jcd_pkg.sv
package jcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REPLY = 2'd1,
        ST_QUIT  = 2'd2
    } jcd_state_e;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_PINS    = 3'd1,
        K_RELEASE = 3'd2,
        K_ASSERT  = 3'd3,
        K_READ    = 3'd4,
        K_QUIT    = 3'd5
    } jcd_kind_e;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ASC_ZERO = 8'h30;
    localparam logic [BYTE_W-1:0] ASC_ONE  = 8'h31;
endpackage

// File: rtl/jcd_sync.sv
module jcd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES < 2) begin : g_single
            logic r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= 1'b0;
                else        r <= d_i;
            end
            assign q_o = r;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
            assign q_o = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/jcd_decode.sv
module jcd_decode
    import jcd_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output jcd_kind_e         kind_o
);
    always_comb begin
        if (byte_i[7:3] == 5'b00110) begin
            kind_o = K_PINS;
        end else begin
            unique case (byte_i)
                8'h72, 8'h73: kind_o = K_RELEASE;
                8'h74, 8'h75: kind_o = K_ASSERT;
                8'h52:        kind_o = K_READ;
                8'h51:        kind_o = K_QUIT;
                default:      kind_o = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/jcd_ctrl.sv
module jcd_ctrl
    import jcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  jcd_kind_e         kind_i,
    input  logic              tdo_s_i,
    input  logic              rsp_ready_i,
    output logic              rsp_valid_o,
    output logic [BYTE_W-1:0] rsp_byte_o,
    output logic              cmd_ready_o,
    output logic              quit_o
);
    jcd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_i && kind_i == K_READ)      state_d = ST_REPLY;
                else if (accept_i && kind_i == K_QUIT) state_d = ST_QUIT;
            end
            ST_REPLY: if (rsp_ready_i) state_d = ST_IDLE;
            ST_QUIT:  state_d = ST_QUIT;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_byte_o <= ASC_ZERO;
        end else if (state_q == ST_IDLE && accept_i && kind_i == K_READ) begin
            rsp_byte_o <= tdo_s_i ? ASC_ONE : ASC_ZERO;
        end
    end

    assign rsp_valid_o = (state_q == ST_REPLY);
    assign cmd_ready_o = (state_q != ST_REPLY);
    assign quit_o      = (state_q == ST_QUIT);

    // R6
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_byte_o));
    // R6
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !cmd_ready_o);
    // R7
    quit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quit_o |=> quit_o);
endmodule

// File: rtl/jtag_char_driver.sv
module jtag_char_driver
    import jcd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [7:0] cmd_byte,
    output logic       rsp_valid,
    input  logic       rsp_ready,
    output logic [7:0] rsp_byte,
    input  logic       tdo,
    output logic       tck,
    output logic       tms,
    output logic       tdi,
    output logic       trst_n,
    output logic       step,
    output logic       quit
);
    logic      accept;
    logic      live;
    logic      tdo_s;
    jcd_kind_e kind;

    assign accept = cmd_valid && cmd_ready;
    assign live   = accept && !quit;

    jcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst_n (rst_n), .d_i (tdo), .q_o (tdo_s)
    );

    jcd_decode u_dec (.byte_i (cmd_byte), .kind_o (kind));

    jcd_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .kind_i      (kind),
        .tdo_s_i     (tdo_s),
        .rsp_ready_i (rsp_ready),
        .rsp_valid_o (rsp_valid),
        .rsp_byte_o  (rsp_byte),
        .cmd_ready_o (cmd_ready),
        .quit_o      (quit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tck    <= 1'b0;
            tms    <= 1'b0;
            tdi    <= 1'b0;
            trst_n <= 1'b0;
            step   <= 1'b0;
        end else begin
            step <= live && (kind == K_PINS || kind == K_RELEASE);
            if (live && kind == K_PINS) begin
                tck <= cmd_byte[2];
                tms <= cmd_byte[1];
                tdi <= cmd_byte[0];
            end
            if (live && kind == K_RELEASE) trst_n <= 1'b1;
            if (live && kind == K_ASSERT)  trst_n <= 1'b0;
        end
    end

    // R2
    pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable({tck, tms, tdi, trst_n}));
    // R4
    step_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !step);
    // R7
    quit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quit |=> $stable({tck, tms, tdi, trst_n}) && !step);
endmodule

// File: tb/tb_jtag_char_driver.sv
module tb_jtag_char_driver;
    localparam int TB_SYNC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       rsp_ready = 1'b1;
    logic       tdo = 1'b0;
    logic       cmd_ready, rsp_valid, tck, tms, tdi, trst_n, step, quit;
    logic [7:0] rsp_byte;

    int errs = 0;
    int checks = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    jtag_char_driver #(.SYNC_STAGES(TB_SYNC)) dut (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
        .cmd_byte (cmd_byte), .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
        .rsp_byte (rsp_byte), .tdo (tdo), .tck (tck), .tms (tms), .tdi (tdi),
        .trst_n (trst_n), .step (step), .quit (quit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_pins(input string req, input logic [3:0] exp);
        chk({tck, tms, tdi, trst_n} == exp, req, {tck, tms, tdi, trst_n}, exp);
    endtask

    task automatic send(input logic [7:0] b);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic settle_tdo(input logic v);
        tdo = v;
        repeat (TB_SYNC + 2) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    // scoreboard monitor: compare each reply byte as it is handed over
    initial begin
        logic [7:0] e;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && rsp_valid && rsp_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", rsp_byte, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rsp_byte == e, "R5", rsp_byte, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL R6 watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_pins("R1", 4'b0000);
        chk(!step && !rsp_valid && !quit, "R1", {step, rsp_valid, quit}, 0);
        chk(cmd_ready == 1'b1, "R1", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk_pins("R1", 4'b0000);

        // R3 release, R4 step
        send(8'h72);
        chk_pins("R3", 4'b0001);
        chk(step == 1'b1, "R4", step, 1);
        @(negedge clk);
        chk(step == 1'b0, "R4", step, 0);

        // R2 all digits
        for (int d = 0; d < 8; d++) begin
            send(8'h30 + 8'(d));
            chk_pins("R2", {3'(d), 1'b1});
            chk(step == 1'b1, "R4", step, 1);
        end

        // R3 assert/release variants, no step on assert
        send(8'h74);
        chk_pins("R3", 4'b1110);
        chk(step == 1'b0, "R4", step, 0);
        send(8'h73);
        chk_pins("R3", 4'b1111);
        send(8'h75);
        chk_pins("R3", 4'b1110);
        send(8'h72);
        chk_pins("R3", 4'b1111);

        // R5 reads
        settle_tdo(1'b1);
        exp_q.push_back(8'h31);
        send(8'h52);
        chk_pins("R5", 4'b1111);
        chk(step == 1'b0, "R5", step, 0);
        settle_tdo(1'b0);
        exp_q.push_back(8'h30);
        send(8'h52);

        // R6 backpressure
        settle_tdo(1'b1);
        rsp_ready = 1'b0;
        exp_q.push_back(8'h31);
        send(8'h52);
        cmd_valid = 1'b1;
        cmd_byte  = 8'h30;
        repeat (3) begin
            @(negedge clk);
            chk(cmd_ready == 1'b0, "R6", cmd_ready, 0);
            chk(rsp_valid && rsp_byte == 8'h31, "R6", {rsp_valid, rsp_byte}, 9'h131);
            chk_pins("R6", 4'b1111);
        end
        rsp_ready = 1'b1;
        send(8'h30);
        chk_pins("R6", 4'b0001);

        // R8 unknown bytes
        send(8'h35);
        chk_pins("R2", 4'b1011);
        send(8'h78);
        chk_pins("R8", 4'b1011);
        chk(!step && !rsp_valid && !quit, "R8", {step, rsp_valid, quit}, 0);
        send(8'h38);
        chk_pins("R8", 4'b1011);
        chk(step == 1'b0, "R8", step, 0);
        send(8'h2F);
        chk_pins("R8", 4'b1011);

        // R7 quit
        send(8'h51);
        chk(quit == 1'b1, "R7", quit, 1);
        chk(step == 1'b0, "R7", step, 0);
        send(8'h32);
        chk_pins("R7", 4'b1011);
        chk(step == 1'b0 && quit, "R7", {step, quit}, 1);
        send(8'h74);
        chk_pins("R7", 4'b1011);
        send(8'h52);
        repeat (2) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R7", rsp_valid, 0);
        end
        chk(quit == 1'b1, "R7", quit, 1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule